// File: doc/BRIEF.md
# Three-wire serial EEPROM host controller

This block sits on the host side of a three-wire serial EEPROM link. It drives the chip-select, serial clock and serial data lines to the memory and samples the memory's serial data output. A single command port takes an operation, an address, a write word, a word-width setting and an auto-lock flag. The block turns these into a serial frame, clocks the frame out, and collects the read word. For operations that program the array, it then re-selects the device and waits until the device reports that it is ready.

The serial clock comes from a divider of the system clock. Between any two chip-select-high windows, chip select is held low for a programmable number of system cycles. While a command runs, `busy` is high and new commands are ignored. When the command is complete, `done` pulses for one cycle. For a read, the word is presented on `rd_data` in that same cycle. If a ready status does not arrive within a set number of cycles, the block raises an error flag and still finishes the command.

Top module: `sereep_host`

## Requirements
- R1: A frame is a 1 start bit, then a 2-bit opcode (read 10, write 01, erase 11, extended 00), then the address field, all sent MSB first. The address field is 9 bits (`cmd_addr[8:0]`) when `cmd_wide`=0 and 8 bits (`cmd_addr[7:0]`) when `cmd_wide`=1. For extended commands, the top two field bits select the command (erase-all 10, write-all 01, enable 11, disable 00) and the remaining field bits are 0. The `cmd_op` codes are: read 0, write 1, erase 2, erase-all 3, write-all 4, enable 5, disable 6.
- R2: Write and write-all frames append the data word MSB first: `cmd_wdata[7:0]` in 8-bit mode and `cmd_wdata[15:0]` in 16-bit mode. All other frames end after the address field. A read frame lasts for the address field plus one word length of clocks, with data-in held at 0 after the field.
- R3: `ee_sk` stays high for exactly CLK_DIV system cycles per pulse. `ee_di` changes only while `ee_sk` is low, and never in the cycle in which `ee_sk` rises.
- R4: On a read, the bit sampled after the last address bit is discarded. The next 8 or 16 sampled bits form the word. In 8-bit mode the word is zero-extended on `rd_data`.
- R5: Every chip-select low interval between two high windows lasts at least CSL_CYC system cycles.
- R6: After a write, erase, erase-all or write-all frame, chip select returns high with `ee_sk` held low. It stays high until `ee_do` is sampled as 1, and then goes low. `ee_sk` is never high while chip select is low.
- R7: If `cmd_lock` is 1 when a programming command is accepted, a disable frame follows the status poll. No such frame follows a read, enable or disable command.
- R8: `busy` is high from the cycle after a command is accepted until `done`. A `cmd_valid` that arrives while `busy` is high produces no frame.
- R9: `done` is a one-cycle pulse. `rd_data` is valid with it and holds its value until the next read completes.
- R10: If ready is not seen within POLL_LIMIT cycles of polling, `timeout_err` is set and chip select drops. `done` still pulses, and no disable frame is sent. The flag is cleared when the next command is accepted.
- R11: While reset is applied and after it is released, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `timeout_err` are all 0.
- R12: Read, enable and disable commands never open a polling window. `done` follows the chip-select low interval after their frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_op | input | 3 | Operation code (see R1) |
| cmd_addr | input | AW8 | Word address |
| cmd_wdata | input | DW | Word to write |
| cmd_wide | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| cmd_lock | input | 1 | Send disable after a programming command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Read word |
| timeout_err | output | 1 | Ready status not seen in time |
| ee_cs | output | 1 | Chip select to the memory |
| ee_sk | output | 1 | Serial clock to the memory |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The bench models the memory at the pins. It checks each frame bit by bit in both word widths, so a design that used the wrong field width, extended code or data slice would show a mismatch. The read tests catch an off-by-one capture: a design that kept the dummy bit would return the word shifted by one place. The bench also counts polling windows and disable frames. This exposes a design that polls after a read, skips the poll after an erase-all, or sends a disable frame after a timeout. Finally, a command poked in during a busy period, and a memory that never reports ready, test R8 and R10.

// File: rtl/sereep_pkg.sv
package sereep_pkg;
  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ERASE     = 3'd2,
    OP_ERASE_ALL = 3'd3,
    OP_WRITE_ALL = 3'd4,
    OP_WREN      = 3'd5,
    OP_WRDIS     = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LO, ST_HI, ST_GAP, ST_POLL, ST_DONE
  } st_e;
endpackage

// File: rtl/sereep_frame.sv
// Builds a left-aligned serial frame and its clock count.
module sereep_frame import sereep_pkg::*; #(
  parameter int AW8 = 9,
  parameter int DW  = 16,
  parameter int FW  = 3 + (AW8 - 1) + DW,
  parameter int LW  = $clog2(FW + 1)
) (
  input  logic [2:0]     op,
  input  logic [AW8-1:0] addr,
  input  logic [DW-1:0]  wdata,
  input  logic           wide,
  output logic [FW-1:0]  frame,
  output logic [LW-1:0]  nbits
);
  localparam int AW16 = AW8 - 1;
  localparam int HW   = DW / 2;
  localparam int H8   = 3 + AW8;
  localparam int H16  = 3 + AW16;
  localparam int PAD  = FW - H8 - HW;

  logic [1:0]      opc, ext;
  logic            use_addr, has_data, has_word;
  logic [AW8-1:0]  f8;
  logic [AW16-1:0] f16;
  logic [HW-1:0]   d8;
  logic [DW-1:0]   d16;

  always_comb begin
    opc = 2'b00; ext = 2'b00; use_addr = 1'b0;
    case (op_e'(op))
      OP_READ:      begin opc = 2'b10; use_addr = 1'b1; end
      OP_WRITE:     begin opc = 2'b01; use_addr = 1'b1; end
      OP_ERASE:     begin opc = 2'b11; use_addr = 1'b1; end
      OP_ERASE_ALL: ext = 2'b10;
      OP_WRITE_ALL: ext = 2'b01;
      OP_WREN:      ext = 2'b11;
      default:      ext = 2'b00;
    endcase
    has_data = (op_e'(op) == OP_WRITE) || (op_e'(op) == OP_WRITE_ALL);
    has_word = has_data || (op_e'(op) == OP_READ);
    f8  = use_addr ? addr : {ext, {(AW8-2){1'b0}}};
    f16 = use_addr ? addr[AW16-1:0] : {ext, {(AW16-2){1'b0}}};
    d8  = has_data ? wdata[HW-1:0] : '0;
    d16 = has_data ? wdata : '0;
    if (wide) begin
      frame = {1'b1, opc, f16, d16};
      nbits = has_word ? LW'(H16 + DW) : LW'(H16);
    end else begin
      frame = {1'b1, opc, f8, d8, {PAD{1'b0}}};
      nbits = has_word ? LW'(H8 + HW) : LW'(H8);
    end
  end
endmodule

// File: rtl/sereep_tick.sv
// Half-period strobe for the serial clock; restarts whenever disabled.
module sereep_tick #(
  parameter int DIV = 2,
  parameter int CW  = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  logic [CW-1:0] cnt;
  assign tick = en && (cnt == CW'(DIV - 1));
  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sereep_host.sv
module sereep_host import sereep_pkg::*; #(
  parameter int AW8        = 9,
  parameter int DW         = 16,
  parameter int CLK_DIV    = 2,
  parameter int CSL_CYC    = 64,
  parameter int POLL_LIMIT = 1 << 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_op,
  input  logic [AW8-1:0] cmd_addr,
  input  logic [DW-1:0]  cmd_wdata,
  input  logic           cmd_wide,
  input  logic           cmd_lock,
  output logic           busy,
  output logic           done,
  output logic [DW-1:0]  rd_data,
  output logic           timeout_err,
  output logic           ee_cs,
  output logic           ee_sk,
  output logic           ee_di,
  input  logic           ee_do
);
  localparam int FW  = 3 + (AW8 - 1) + DW;
  localparam int LW  = $clog2(FW + 1);
  localparam int HW  = DW / 2;
  localparam int GCW = (CSL_CYC > 1) ? $clog2(CSL_CYC) : 1;
  localparam int PCW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

  st_e            st;
  logic [FW-1:0]  sh, c_frame, l_frame;
  logic [LW-1:0]  left, c_nbits, l_nbits;
  logic [DW-1:0]  rd_sh;
  logic [GCW-1:0] gap;
  logic [PCW-1:0] pc;
  logic           prog_q, rd_q, wide_q, lock_q, polled, locked, tick, c_prog;

  sereep_frame #(.AW8(AW8), .DW(DW), .FW(FW), .LW(LW)) u_cmd_frame (
    .op(cmd_op), .addr(cmd_addr), .wdata(cmd_wdata), .wide(cmd_wide),
    .frame(c_frame), .nbits(c_nbits));

  sereep_frame #(.AW8(AW8), .DW(DW), .FW(FW), .LW(LW)) u_lock_frame (
    .op(3'(OP_WRDIS)), .addr('0), .wdata('0), .wide(wide_q),
    .frame(l_frame), .nbits(l_nbits));

  sereep_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst),
    .en(st == ST_LO || st == ST_HI || st == ST_POLL), .tick(tick));

  assign c_prog = (op_e'(cmd_op) == OP_WRITE) || (op_e'(cmd_op) == OP_ERASE) ||
                  (op_e'(cmd_op) == OP_ERASE_ALL) || (op_e'(cmd_op) == OP_WRITE_ALL);
  assign busy  = (st != ST_IDLE);
  assign ee_di = sh[FW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; ee_cs <= 1'b0; ee_sk <= 1'b0; sh <= '0; left <= '0;
      rd_sh <= '0; rd_data <= '0; done <= 1'b0; timeout_err <= 1'b0;
      gap <= '0; pc <= '0; prog_q <= 1'b0; rd_q <= 1'b0; wide_q <= 1'b0;
      lock_q <= 1'b0; polled <= 1'b0; locked <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          sh <= c_frame; left <= c_nbits; prog_q <= c_prog;
          rd_q <= (op_e'(cmd_op) == OP_READ); wide_q <= cmd_wide;
          lock_q <= cmd_lock; polled <= 1'b0; locked <= 1'b0;
          timeout_err <= 1'b0; ee_cs <= 1'b1; st <= ST_LO;
        end
        ST_LO: if (tick) begin
          ee_sk <= 1'b1; st <= ST_HI;
        end
        ST_HI: if (tick) begin
          ee_sk <= 1'b0;
          rd_sh <= {rd_sh[DW-2:0], ee_do};
          if (left == LW'(1)) begin
            sh <= '0; ee_cs <= 1'b0; gap <= '0; st <= ST_GAP;
          end else begin
            sh <= sh << 1; left <= left - 1'b1; st <= ST_LO;
          end
        end
        ST_GAP: if (gap == GCW'(CSL_CYC - 1)) begin
          gap <= '0;
          if (prog_q && !polled && !timeout_err) begin
            ee_cs <= 1'b1; pc <= '0; st <= ST_POLL;
          end else if (prog_q && lock_q && !locked && !timeout_err) begin
            sh <= l_frame; left <= l_nbits; locked <= 1'b1;
            ee_cs <= 1'b1; st <= ST_LO;
          end else begin
            st <= ST_DONE;
          end
        end else begin
          gap <= gap + 1'b1;
        end
        ST_POLL: begin
          pc <= pc + 1'b1;
          if (tick && ee_do) begin
            polled <= 1'b1; ee_cs <= 1'b0; st <= ST_GAP;
          end else if (pc == PCW'(POLL_LIMIT - 1)) begin
            timeout_err <= 1'b1; ee_cs <= 1'b0; st <= ST_GAP;
          end
        end
        ST_DONE: begin
          done <= 1'b1;
          if (rd_q) rd_data <= wide_q ? rd_sh : {{(DW-HW){1'b0}}, rd_sh[HW-1:0]};
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sereep_host_chk.sv
module sereep_host_chk #(
  parameter int CSL_CYC = 64
) (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic timeout_err,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di
);
  localparam int LCW = $clog2(CSL_CYC + 1);
  logic [LCW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)                           low_cnt <= LCW'(CSL_CYC);
    else if (ee_cs)                    low_cnt <= '0;
    else if (low_cnt < LCW'(CSL_CYC))  low_cnt <= low_cnt + 1'b1;
  end

  // R3
  di_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ee_sk |-> $stable(ee_di));
  // R6
  sk_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    ee_sk |-> ee_cs);
  // R5
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_cs) |-> (low_cnt >= LCW'(CSL_CYC)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy);
  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R10
  err_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> !ee_cs);
endmodule

bind sereep_host sereep_host_chk #(.CSL_CYC(CSL_CYC)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .timeout_err(timeout_err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di));

// File: tb/sereep_host_test.sv
`timescale 1ns/1ps
module sereep_host_test;
  localparam int DIV = 2, CSL = 64, PLIM = 3000, BUSY_T = 400;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, cmd_valid = 1'b0, cmd_wide = 1'b0, cmd_lock = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [8:0]  cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        busy, done, timeout_err, ee_cs, ee_sk, ee_di;
  logic [15:0] rd_data;
  logic        ee_do = 1'b0;

  sereep_host #(.CLK_DIV(DIV), .CSL_CYC(CSL), .POLL_LIMIT(PLIM)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_wide(cmd_wide),
    .cmd_lock(cmd_lock), .busy(busy), .done(done), .rd_data(rd_data),
    .timeout_err(timeout_err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do));

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rdpat(input int field);
    return 16'h5A3C ^ 16'(field * 257);
  endfunction

  // Expected frame from R1/R2: returns length and right-aligned bits.
  task automatic mk(input int op, input int addr, input int wd, input bit wide,
                    output int len, output logic [31:0] bits);
    int fw, w, opc, ext, field; bit ua;
    fw = wide ? 8 : 9; w = wide ? 16 : 8; ext = 0; opc = 0; ua = 0;
    case (op)
      0: begin opc = 2; ua = 1; end
      1: begin opc = 1; ua = 1; end
      2: begin opc = 3; ua = 1; end
      3: ext = 2;
      4: ext = 1;
      5: ext = 3;
      default: ext = 0;
    endcase
    field = ua ? (addr & ((1 << fw) - 1)) : (ext << (fw - 2));
    bits = 32'd1;
    bits = (bits << 2) | 32'(opc);
    bits = (bits << fw) | 32'(field);
    len = 3 + fw;
    if (op == 1 || op == 4) begin
      bits = (bits << w) | 32'(wd & ((1 << w) - 1)); len += w;
    end else if (op == 0) begin
      bits = bits << w; len += w;
    end
  endtask

  // Scoreboard queues
  int          exp_len[$];
  logic [31:0] exp_bits[$];

  // Memory model and monitor, all at the falling system-clock edge
  bit          prev_cs = 0, prev_sk = 0, rd_act = 0, stuck = 0, cur_wide = 0;
  int          k = 0, busy_left = 0, low_cnt = 1000, hi_cnt = 0, polls = 0;
  logic [31:0] cap = '0;
  logic [15:0] rdw = '0;

  always @(negedge clk) begin
    int h, w, op, ext;
    h = cur_wide ? 11 : 12; w = cur_wide ? 16 : 8;
    if (busy_left > 0 && !stuck) busy_left--;
    if (ee_cs && !prev_cs) begin
      chk(low_cnt >= CSL, "R5", "chip-select low cycles", low_cnt, CSL);
      k = 0; cap = '0;
    end
    if (!ee_cs) low_cnt++; else low_cnt = 0;
    if (ee_sk && !prev_sk && ee_cs) begin
      cap = {cap[30:0], ee_di}; k++;
      if (k == h) begin
        op = int'((cap >> (h - 3)) & 32'd3);
        if (op == 2) begin
          rd_act = 1; rdw = rdpat(int'(cap & ((32'd1 << (h - 3)) - 1)));
          if (!cur_wide) rdw = {8'h00, rdw[7:0]};
        end
        ee_do = 1'b0;
      end else if (k > h && rd_act) begin
        ee_do = rdw[w - (k - h)];
      end
    end
    if (ee_sk) hi_cnt++;
    if (!ee_sk && prev_sk) begin
      chk(hi_cnt == DIV, "R3", "serial clock high cycles", hi_cnt, DIV);
      hi_cnt = 0;
    end
    if (!ee_cs && prev_cs) begin
      if (k == 0) polls++;
      else begin
        op  = int'((cap >> (k - 3)) & 32'd3);
        ext = int'((cap >> (k - 5)) & 32'd3);
        if (op == 1 || op == 3 || (op == 0 && (ext == 2 || ext == 1)))
          busy_left = BUSY_T;
        if (exp_len.size() == 0) begin
          chk(0, "R8", "unexpected frame", cap, 0);
        end else begin
          int el; logic [31:0] eb;
          el = exp_len.pop_front(); eb = exp_bits.pop_front();
          chk(k == el, "R1", "frame length", k, el);
          chk(cap == eb, "R2", "frame bits", cap, eb);
        end
      end
      rd_act = 0; ee_do = 1'b0;
    end
    if (ee_cs && k == 0) ee_do = (busy_left == 0) && !stuck;
    prev_cs = ee_cs; prev_sk = ee_sk;
  end

  logic [15:0] last_rd = '0;

  // Driver: pushes expected frames, issues command, checks completion
  task automatic run(input int op, input int addr, input int wd, input bit wide,
                     input bit lock, input int exp_polls, input bit exp_err,
                     input bit poke, input string req);
    int len; logic [31:0] bits; bit prog;
    prog = (op >= 1 && op <= 4);
    mk(op, addr, wd, wide, len, bits);
    exp_len.push_back(len); exp_bits.push_back(bits);
    if (lock && prog && !exp_err) begin
      mk(6, 0, 0, wide, len, bits);
      exp_len.push_back(len); exp_bits.push_back(bits);
    end
    cur_wide = wide; polls = 0;
    @(negedge clk);
    cmd_op = 3'(op); cmd_addr = 9'(addr); cmd_wdata = 16'(wd);
    cmd_wide = wide; cmd_lock = lock; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      cmd_op = 3'd3; cmd_valid = 1'b1;   // R8: ignored while busy
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    if (op == 0) begin
      logic [15:0] e;
      e = rdpat(addr & (wide ? 255 : 511));
      if (!wide) e = {8'h00, e[7:0]};
      chk(rd_data == e, "R4", {req, " read word"}, rd_data, e);
      last_rd = e;
    end else begin
      chk(rd_data == last_rd, "R9", {req, " read word held"}, rd_data, last_rd);
    end
    chk(timeout_err == exp_err, "R10", {req, " error flag"}, timeout_err, exp_err);
    chk(polls == exp_polls, prog ? "R6" : "R12", {req, " poll windows"}, polls, exp_polls);
    chk(exp_len.size() == 0, "R7", {req, " frames outstanding"}, exp_len.size(), 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9", {req, " done one cycle"}, {done, busy}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk({ee_cs, ee_sk, ee_di, busy, done, timeout_err} == 6'b0, "R11",
        "outputs in reset", {ee_cs, ee_sk, ee_di, busy, done, timeout_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({ee_cs, ee_sk, ee_di, busy, done, timeout_err} == 6'b0, "R11",
        "outputs after reset", {ee_cs, ee_sk, ee_di, busy, done, timeout_err}, 0);
    run(5, 0,     0,      0, 0, 0, 0, 0, "R1 enable x8");
    run(1, 9'h1A5, 16'h3C, 0, 0, 1, 0, 0, "R2 write x8");
    run(0, 9'h1A5, 0,      0, 0, 0, 0, 0, "R4 read x8");
    run(0, 9'h07E, 0,      1, 0, 0, 0, 0, "R4 read x16");
    run(1, 9'h081, 16'hBEEF, 1, 1, 1, 0, 0, "R7 write x16 locked");
    run(2, 9'h022, 0,      1, 0, 1, 0, 1, "R8 erase with poke");
    run(3, 0,     0,      0, 1, 1, 0, 0, "R7 erase-all locked");
    run(4, 0,     16'h1234, 1, 0, 1, 0, 0, "R2 write-all x16");
    run(6, 0,     0,      1, 0, 0, 0, 0, "R12 disable x16");
    run(0, 9'h1FF, 0,      0, 1, 0, 0, 0, "R7 read with lock");
    stuck = 1;
    run(1, 9'h010, 16'h77, 0, 1, 1, 1, 0, "R10 stuck device");
    stuck = 0; busy_left = 0;
    run(5, 0,     0,      1, 0, 0, 0, 0, "R10 clear on next");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule